// File: doc/BRIEF.md
# UART Bit Clock Generator

This block derives all bit timing for an asynchronous serial link from a single system clock. A programmable reload divider, or an external clock input used in its place, produces a base tick. An oversampling counter then divides the base tick by 8 or 16, and that counter yields a bit-boundary strobe and a mid-bit sample strobe. A double-speed control halves the base-tick period on its own. Combined with the 8x setting, it gives four times the default bit rate.

A small transmit shifter sends one character per request. The character is a low start bit, eight data bits least-significant first, an optional parity bit and a high stop bit. The shifter also drives a serial clock output that is low for the first half of every frame bit, rises at the middle of the bit, and rests high between frames. The frame shows how the data and that clock line up in phase. Timing settings are taken into use only while no frame is in flight. Each time one is taken, the counters restart, so no partial bit is emitted.

Top module: `uart_bitclk_gen`

## Requirements
- R1: With the internal divider selected and divider value N, `base_tick` pulses once every N+1 clock cycles when `dbl_speed` is 1 and once every 2(N+1) cycles when `dbl_speed` is 0.
- R2: One bit period (the spacing of `bit_tick` pulses) is 16 base ticks when `os_sel8` is 0 and 8 base ticks when `os_sel8` is 1.
- R3: For a fixed N, the four settings (`dbl_speed`,`os_sel8`) = 00, 10, 01, 11 give bit periods in the ratio 4:2:2:1, so the last setting runs at four times the rate of the first.
- R4: With `ext_clk_sel` = 1, each rising edge of `ext_clk_in` produces one base tick after a two-stage synchronizer, independent of N and `dbl_speed`.
- R5: `mid_tick` pulses exactly half an oversampling count (8 or 4 base ticks) after each `bit_tick`. Both strobes only occur together with `base_tick`, and never in the same cycle as each other.
- R6: A request on `tx_start` while idle starts a frame on the next `bit_tick`. On `txd` the frame is a 0 start bit, data bits 0 to 7 in order, then a parity bit when `parity_en` = 1, then a 1 stop bit. Each bit lasts one bit period. The parity bit is the XOR of the data bits, inverted when `parity_odd` = 1.
- R7: When idle, `txd` is 1 and `tx_busy` is 0. A `tx_start` pulse while `tx_busy` is 1 is ignored: the frame in flight is unchanged and no second frame follows.
- R8: With `clk_out_en` = 1 and the internal divider selected, `sclk_out` is 0 during the first half of every frame bit and rises in the clock cycle after `mid_tick`. It is 1 whenever `tx_busy` is 0 and whenever the output is disabled or the external clock is selected.
- R9: A change on `dbl_speed`, `os_sel8` or `ext_clk_sel` is taken into use only when `tx_busy` is 0. Taking it restarts the divider and the oversampling counter.
- R10: After reset, `txd` and `sclk_out` are 1 and `tx_busy`, `base_tick`, `bit_tick` and `mid_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | DIV_W | Divider reload value N |
| dbl_speed | input | 1 | 1 doubles the divider output rate |
| os_sel8 | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| ext_clk_sel | input | 1 | 1 takes the base clock from ext_clk_in |
| ext_clk_in | input | 1 | External base clock, asynchronous |
| clk_out_en | input | 1 | Enables the serial clock output |
| parity_en | input | 1 | Appends a parity bit to the frame |
| parity_odd | input | 1 | Selects odd parity when 1 |
| tx_start | input | 1 | Single-cycle request to send tx_data |
| tx_data | input | DATA_W | Character to send |
| base_tick | output | 1 | Oversampling strobe |
| bit_tick | output | 1 | Bit-boundary strobe |
| mid_tick | output | 1 | Mid-bit sample strobe |
| sclk_out | output | 1 | Serial clock, rising at the middle of each bit |
| txd | output | 1 | Serial data out |
| tx_busy | output | 1 | A frame is pending or in flight |

## Verification
The bench measures the bit period and the offset of the mid-bit strobe for all four rate settings and for the external clock. This catches a divider that misses the double-speed step, or a counter that wraps at the wrong count, and would show up as a wrong rate ratio. It samples `txd` at every mid-bit strobe across frames with and without parity, and checks `sclk_out` just before and just after the rise. A shifter that is off by one bit, or a clock whose phase is off by half a bit, fails these checks. It also changes the rate and sends a second request while a frame is in flight. A design that applies settings at once would distort the current bit periods, and one that queues the request would send an extra frame.

// File: rtl/uart_bitclk_pkg.sv
package uart_bitclk_pkg;

  typedef struct packed {
    logic ext;   // external base clock selected
    logic dbl;   // double speed
    logic os8;   // 8x oversampling
  } bclk_cfg_t;

  localparam int OS_W = 4;

  function automatic logic [OS_W-1:0] os_last(input logic os8);
    return os8 ? OS_W'(7) : OS_W'(15);
  endfunction

  function automatic logic [OS_W-1:0] os_half_m1(input logic os8);
    return os8 ? OS_W'(3) : OS_W'(7);
  endfunction

endpackage

// File: rtl/bclk_div.sv
module bclk_div #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_val,
  input  logic             dbl,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             half_q;
  logic             reload;

  assign reload = (cnt_q == '0);
  assign tick   = reload && (dbl || half_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= div_val;
      half_q <= 1'b0;
    end else if (reload) begin
      cnt_q  <= div_val;
      half_q <= ~half_q;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/bclk_ext_edge.sv
module bclk_ext_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  output logic rise
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC_STAGES-1:0], ext_in};
  end

  assign rise = sh_q[SYNC_STAGES-1] && !sh_q[SYNC_STAGES];
endmodule

// File: rtl/bclk_os_cnt.sv
module bclk_os_cnt
  import uart_bitclk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic os8,
  output logic base_tick,
  output logic bit_tick,
  output logic mid_tick
);
  logic [OS_W-1:0] cnt_q;
  logic [OS_W-1:0] last;
  logic [OS_W-1:0] half_m1;

  assign last    = os_last(os8);
  assign half_m1 = os_half_m1(os8);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q     <= '0;
      base_tick <= 1'b0;
      bit_tick  <= 1'b0;
      mid_tick  <= 1'b0;
    end else begin
      base_tick <= tick;
      bit_tick  <= tick && (cnt_q == last);
      mid_tick  <= tick && (cnt_q == half_m1);
      if (tick) cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bclk_tx.sv
module bclk_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              mid_tick,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              clk_en,
  output logic              txd,
  output logic              sclk,
  output logic              busy
);
  localparam int SH_W  = DATA_W + 2;
  localparam int CNT_W = $clog2(DATA_W + 3);

  logic              pend_q, act_q;
  logic [CNT_W-1:0]  rem_q;
  logic [SH_W-1:0]   sh_q;
  logic              par_bit;
  logic              more;

  assign par_bit = (^data) ^ par_odd;
  assign busy    = pend_q || act_q;
  assign more    = pend_q || (act_q && (rem_q != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      rem_q  <= '0;
      sh_q   <= '1;
      txd    <= 1'b1;
      sclk   <= 1'b1;
    end else begin
      if (start && !busy) pend_q <= 1'b1;
      if (bit_tick) begin
        sclk <= !(clk_en && more);
        if (pend_q) begin
          pend_q <= 1'b0;
          act_q  <= 1'b1;
          txd    <= 1'b0;
          sh_q   <= {1'b1, par_en ? par_bit : 1'b1, data};
          rem_q  <= CNT_W'(DATA_W + 1) + CNT_W'(par_en);
        end else if (act_q) begin
          if (rem_q != '0) begin
            txd   <= sh_q[0];
            sh_q  <= {1'b1, sh_q[SH_W-1:1]};
            rem_q <= rem_q - 1'b1;
          end else begin
            act_q <= 1'b0;
            txd   <= 1'b1;
          end
        end
      end else if (mid_tick) begin
        sclk <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_bitclk_gen.sv
module uart_bitclk_gen
  import uart_bitclk_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              dbl_speed,
  input  logic              os_sel8,
  input  logic              ext_clk_sel,
  input  logic              ext_clk_in,
  input  logic              clk_out_en,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              tx_start,
  input  logic [DATA_W-1:0] tx_data,
  output logic              base_tick,
  output logic              bit_tick,
  output logic              mid_tick,
  output logic              sclk_out,
  output logic              txd,
  output logic              tx_busy
);
  bclk_cfg_t cfg_q, cfg_live;
  logic      apply;
  logic      div_tick, ext_rise, raw_tick;

  assign cfg_live = '{ext: ext_clk_sel, dbl: dbl_speed, os8: os_sel8};
  assign apply    = !tx_busy && (cfg_live != cfg_q);

  always_ff @(posedge clk) begin
    if (rst)        cfg_q <= '0;
    else if (apply) cfg_q <= cfg_live;
  end

  bclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .clr(apply), .div_val(div_val),
    .dbl(cfg_q.dbl), .tick(div_tick)
  );

  bclk_ext_edge #(.SYNC_STAGES(2)) u_ext (
    .clk(clk), .rst(rst), .ext_in(ext_clk_in), .rise(ext_rise)
  );

  assign raw_tick = cfg_q.ext ? ext_rise : div_tick;

  bclk_os_cnt u_os (
    .clk(clk), .rst(rst), .clr(apply), .tick(raw_tick), .os8(cfg_q.os8),
    .base_tick(base_tick), .bit_tick(bit_tick), .mid_tick(mid_tick)
  );

  bclk_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .mid_tick(mid_tick),
    .start(tx_start), .data(tx_data), .par_en(parity_en),
    .par_odd(parity_odd), .clk_en(clk_out_en && !cfg_q.ext),
    .txd(txd), .sclk(sclk_out), .busy(tx_busy)
  );
endmodule

// File: rtl/uart_bitclk_chk.sv
module uart_bitclk_chk
  import uart_bitclk_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      base_tick,
  input logic      bit_tick,
  input logic      mid_tick,
  input logic      sclk_out,
  input logic      txd,
  input logic      tx_busy,
  input bclk_cfg_t cfg_q
);
  // R5
  bit_on_base_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_tick || mid_tick) |-> base_tick);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bit_tick && mid_tick));
  // R7
  idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);
  // R8
  idle_sclk_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> sclk_out);
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(tx_busy) |-> $stable(cfg_q));
endmodule

bind uart_bitclk_gen uart_bitclk_chk u_chk (
  .clk(clk), .rst(rst), .base_tick(base_tick), .bit_tick(bit_tick),
  .mid_tick(mid_tick), .sclk_out(sclk_out), .txd(txd), .tx_busy(tx_busy),
  .cfg_q(cfg_q)
);

// File: tb/sim_uart_bitclk_gen.sv
`timescale 1ns/1ps
module sim_uart_bitclk_gen;
  localparam int DIV_W = 12;
  localparam int DATA_W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [DIV_W-1:0] div_val = '0;
  logic dbl_speed = 0, os_sel8 = 0, ext_clk_sel = 0, ext_clk_in = 0;
  logic clk_out_en = 0, parity_en = 0, parity_odd = 0, tx_start = 0;
  logic [DATA_W-1:0] tx_data = '0;
  logic base_tick, bit_tick, mid_tick, sclk_out, txd, tx_busy;

  int errors = 0, checks = 0, cyc = 0;
  logic ext_run = 0;
  int ext_cnt = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (ext_run) begin
      ext_cnt <= (ext_cnt == 4) ? 0 : ext_cnt + 1;
      if (ext_cnt == 4) ext_clk_in <= ~ext_clk_in;
    end
  end

  uart_bitclk_gen #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(input int n, input bit dbl, input bit os8);
    return (os8 ? 8 : 16) * (n + 1) * (dbl ? 1 : 2);
  endfunction

  task automatic wait_bt(output int c);
    do @(negedge clk); while (!bit_tick);
    c = cyc;
  endtask

  task automatic wait_mid(output int c);
    do @(negedge clk); while (!mid_tick);
    c = cyc;
  endtask

  task automatic measure(input int n, input bit dbl, input bit os8, output int per);
    int t0, t1, tm, t2, e;
    @(negedge clk);
    div_val = DIV_W'(n); dbl_speed = dbl; os_sel8 = os8;
    wait_bt(t0); wait_bt(t1); wait_mid(tm); wait_bt(t2);
    per = t2 - t1;
    e = exp_period(n, dbl, os8);
    chk(per == e, "R1/R2 bit period", per, e);
    chk(tm - t1 == e / 2, "R5 mid offset", tm - t1, e / 2);
  endtask

  // R6 frame content and R8 clock phase
  task automatic send_frame(input logic [7:0] d, input bit pe, input bit po, input bit ce);
    logic [10:0] bits;
    int nb, c0, cm;
    bits = {1'b1, (^d) ^ po, d, 1'b0};
    if (!pe) bits = {1'b1, 1'b1, d, 1'b0};
    nb = pe ? 11 : 10;
    @(negedge clk);
    tx_data = d; parity_en = pe; parity_odd = po; clk_out_en = ce; tx_start = 1;
    @(negedge clk);
    tx_start = 0;
    chk(tx_busy == 1, "R6 busy after request", int'(tx_busy), 1);
    wait_bt(c0);
    for (int i = 0; i < nb; i++) begin
      wait_mid(cm);
      chk(txd == bits[i], "R6 frame bit", int'(txd), int'(bits[i]));
      chk(sclk_out == !ce, "R8 sclk first half", int'(sclk_out), int'(!ce));
      if (i == 3) begin
        tx_data = ~d; tx_start = 1;   // R7 request while busy
      end
      @(negedge clk);
      tx_start = 0;
      chk(sclk_out == 1, "R8 sclk after mid", int'(sclk_out), 1);
    end
    wait_bt(c0);
    @(negedge clk);
    chk(tx_busy == 0 && txd == 1, "R7 idle after frame", int'(tx_busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p00, p10, p01, p11, n, pe, t0, t1, t2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(txd == 1 && sclk_out == 1, "R10 line high", int'({txd, sclk_out}), 3);
    chk(!tx_busy && !base_tick && !bit_tick && !mid_tick, "R10 idle strobes",
        int'({tx_busy, base_tick, bit_tick, mid_tick}), 0);
    rst = 0;

    for (int k = 0; k < 2; k++) begin
      n = (k == 0) ? 0 : 1 + int'($urandom_range(4));
      measure(n, 0, 0, p00);
      measure(n, 1, 0, p10);
      measure(n, 0, 1, p01);
      measure(n, 1, 1, p11);
      // R3 rate ratios
      chk(p00 == 2 * p10, "R3 double speed 2x", p10 * 2, p00);
      chk(p00 == 2 * p01, "R3 8x oversampling 2x", p01 * 2, p00);
      chk(p00 == 4 * p11, "R3 combined 4x", p11 * 4, p00);
    end

    // frames: random data, with and without parity, clock out on and off
    measure(1, 1, 1, pe);
    for (int k = 0; k < 4; k++)
      send_frame(8'($urandom), k[0], k[1], k != 3);
    send_frame(8'h00, 1, 1, 1);
    send_frame(8'hFF, 1, 0, 1);
    // R7 no second frame
    repeat (40) @(negedge clk);
    chk(tx_busy == 0 && txd == 1, "R7 ignored request", int'(tx_busy), 0);

    // R9 setting change held until idle
    measure(2, 0, 0, pe);
    @(negedge clk);
    tx_data = 8'hA5; parity_en = 0; tx_start = 1;
    @(negedge clk);
    tx_start = 0;
    wait_bt(t0);
    dbl_speed = 1;
    wait_bt(t1); wait_bt(t2);
    chk(t2 - t1 == exp_period(2, 0, 0), "R9 held while busy", t2 - t1, exp_period(2, 0, 0));
    do @(negedge clk); while (tx_busy);
    wait_bt(t0); wait_bt(t1); wait_bt(t2);
    chk(t2 - t1 == exp_period(2, 1, 0), "R9 applied when idle", t2 - t1, exp_period(2, 1, 0));

    // R4 external clock, period 10 cycles
    ext_run = 1;
    @(negedge clk);
    ext_clk_sel = 1; dbl_speed = 0; os_sel8 = 0; clk_out_en = 1;
    wait_bt(t0); wait_bt(t1); wait_bt(t2);
    chk(t2 - t1 == 160, "R4 external 16x", t2 - t1, 160);
    os_sel8 = 1;
    wait_bt(t0); wait_bt(t1); wait_bt(t2);
    chk(t2 - t1 == 80, "R4 external 8x", t2 - t1, 80);
    // R8 clock output suppressed with external clock
    tx_data = 8'h3C; tx_start = 1;
    @(negedge clk);
    tx_start = 0;
    wait_bt(t0); wait_mid(t1);
    chk(sclk_out == 1, "R8 sclk off with external", int'(sclk_out), 1);
    do @(negedge clk); while (tx_busy);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule